// File: doc/BRIEF.md
# AXI4-Lite Three-Way Register Splitter

This block sits between one AXI4-Lite manager and three AXI4-Lite subordinates, each of which holds a single 32-bit register. It has no clock and no storage. Address, protection, write data and byte strobes go out on shared downstream buses. Each address is decoded on the fly, and only one downstream port sees a valid. The ready and response signals of that port are steered straight back upstream.

Writes are decoded from the write address and reads from the read address, each on its own. A read and a write can therefore be in flight to different ports at the same moment. Word-address bits [3:2] pick the port, and every address bit above them must be zero. Any other address reaches no downstream port. The block answers such an address itself with a decode-error response.

Top module: `axil_split3`

## Requirements
- R1: Write decode. Byte address 0x0, 0x4 or 0x8 on `up_awaddr` selects port 0, 1 or 2 respectively. Selection uses bits [3:2], and bits [1:0] are ignored. Only bit p of `dn_awvalid` and of `dn_wvalid` follows `up_awvalid` and `up_wvalid`. The other bits stay 0.
- R2: Read decode. The same mapping is applied to `up_araddr`. Only bit p of `dn_arvalid` follows `up_arvalid`.
- R3: The address, protection, write data and strobe signals of both directions appear unchanged on the shared downstream buses, whether or not the address decodes.
- R4: `up_awready`, `up_wready`, `up_bvalid` and `up_bresp` are taken only from the port selected by `up_awaddr`. `up_arready`, `up_rvalid`, `up_rdata` and `up_rresp` are taken only from the port selected by `up_araddr`. Response codes, including OKAY (0), pass through unchanged. Port k's response occupies bits [2k+1:2k], and its read data occupies bits [32k+31:32k].
- R5: `up_bready` reaches only bit p of `dn_bready`, and `up_rready` reaches only bit p of `dn_rready`. All other bits are 0.
- R6: An address is unmapped when bits [3:2] equal 3 or any bit above bit 3 is set. An unmapped address asserts no downstream valid or response-ready. For an unmapped write: `up_bvalid` = awvalid AND wvalid, `up_awready` = wvalid AND bready, `up_wready` = awvalid AND bready, and `up_bresp` = 2'b11. For an unmapped read: `up_rvalid` = arvalid, `up_arready` = rready, `up_rdata` = 0, and `up_rresp` = 2'b11.
- R7: Write and read decoding are independent. A write to one port and a read from another proceed at the same time without interfering.
- R8: Every output follows its inputs in the same evaluation, with no clock edge. When an upstream valid drops, the matching downstream valid drops at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| up_awaddr | input | AW | Upstream write address |
| up_awprot | input | 3 | Upstream write protection |
| up_awvalid | input | 1 | Upstream write address valid |
| up_awready | output | 1 | Upstream write address ready |
| up_wdata | input | DW | Upstream write data |
| up_wstrb | input | DW/8 | Upstream byte strobes |
| up_wvalid | input | 1 | Upstream write data valid |
| up_wready | output | 1 | Upstream write data ready |
| up_bresp | output | 2 | Upstream write response code |
| up_bvalid | output | 1 | Upstream write response valid |
| up_bready | input | 1 | Upstream write response ready |
| up_araddr | input | AW | Upstream read address |
| up_arprot | input | 3 | Upstream read protection |
| up_arvalid | input | 1 | Upstream read address valid |
| up_arready | output | 1 | Upstream read address ready |
| up_rdata | output | DW | Upstream read data |
| up_rresp | output | 2 | Upstream read response code |
| up_rvalid | output | 1 | Upstream read valid |
| up_rready | input | 1 | Upstream read ready |
| dn_awaddr | output | AW | Shared downstream write address |
| dn_awprot | output | 3 | Shared downstream write protection |
| dn_awvalid | output | NP | Per-port write address valid |
| dn_awready | input | NP | Per-port write address ready |
| dn_wdata | output | DW | Shared downstream write data |
| dn_wstrb | output | DW/8 | Shared downstream strobes |
| dn_wvalid | output | NP | Per-port write data valid |
| dn_wready | input | NP | Per-port write data ready |
| dn_bresp | input | 2*NP | Per-port write response codes |
| dn_bvalid | input | NP | Per-port write response valid |
| dn_bready | output | NP | Per-port write response ready |
| dn_araddr | output | AW | Shared downstream read address |
| dn_arprot | output | 3 | Shared downstream read protection |
| dn_arvalid | output | NP | Per-port read address valid |
| dn_arready | input | NP | Per-port read address ready |
| dn_rdata | input | DW*NP | Per-port read data |
| dn_rresp | input | 2*NP | Per-port read response codes |
| dn_rvalid | input | NP | Per-port read valid |
| dn_rready | output | NP | Per-port read ready |

## Verification
A write and a read can be decoded in the same evaluation, and they may target different ports. They may also mix a mapped and an unmapped address. To provoke this, the bench presents a write to port 0 together with a read from port 2. It then presents a mapped write together with an unmapped read. In each case it judges both channels at the same sample point. The per-port ready and response inputs carry distinct values, so a crossed or shared select shows up as a wrong code or wrong data.

// File: rtl/axil_split3.sv
module axil_split3 #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NP = 3
) (
  input  logic [AW-1:0]    up_awaddr,
  input  logic [2:0]       up_awprot,
  input  logic             up_awvalid,
  output logic             up_awready,
  input  logic [DW-1:0]    up_wdata,
  input  logic [DW/8-1:0]  up_wstrb,
  input  logic             up_wvalid,
  output logic             up_wready,
  output logic [1:0]       up_bresp,
  output logic             up_bvalid,
  input  logic             up_bready,
  input  logic [AW-1:0]    up_araddr,
  input  logic [2:0]       up_arprot,
  input  logic             up_arvalid,
  output logic             up_arready,
  output logic [DW-1:0]    up_rdata,
  output logic [1:0]       up_rresp,
  output logic             up_rvalid,
  input  logic             up_rready,
  output logic [AW-1:0]    dn_awaddr,
  output logic [2:0]       dn_awprot,
  output logic [NP-1:0]    dn_awvalid,
  input  logic [NP-1:0]    dn_awready,
  output logic [DW-1:0]    dn_wdata,
  output logic [DW/8-1:0]  dn_wstrb,
  output logic [NP-1:0]    dn_wvalid,
  input  logic [NP-1:0]    dn_wready,
  input  logic [2*NP-1:0]  dn_bresp,
  input  logic [NP-1:0]    dn_bvalid,
  output logic [NP-1:0]    dn_bready,
  output logic [AW-1:0]    dn_araddr,
  output logic [2:0]       dn_arprot,
  output logic [NP-1:0]    dn_arvalid,
  input  logic [NP-1:0]    dn_arready,
  input  logic [DW*NP-1:0] dn_rdata,
  input  logic [2*NP-1:0]  dn_rresp,
  input  logic [NP-1:0]    dn_rvalid,
  output logic [NP-1:0]    dn_rready
);
  localparam int SW = (NP > 1) ? $clog2(NP) : 1;
  localparam int LO = 2;
  localparam logic [1:0] DECERR = 2'b11;
  localparam logic [NP-1:0] ONE = {{(NP-1){1'b0}}, 1'b1};

  logic [SW-1:0] wsel, rsel;
  logic          whit, rhit;
  logic [NP-1:0] wmask, rmask;

  assign wsel  = up_awaddr[LO +: SW];
  assign rsel  = up_araddr[LO +: SW];
  assign whit  = (up_awaddr[AW-1:LO+SW] == '0) && (int'(wsel) < NP);
  assign rhit  = (up_araddr[AW-1:LO+SW] == '0) && (int'(rsel) < NP);
  assign wmask = whit ? (ONE << wsel) : '0;
  assign rmask = rhit ? (ONE << rsel) : '0;

  assign dn_awaddr  = up_awaddr;
  assign dn_awprot  = up_awprot;
  assign dn_wdata   = up_wdata;
  assign dn_wstrb   = up_wstrb;
  assign dn_araddr  = up_araddr;
  assign dn_arprot  = up_arprot;

  assign dn_awvalid = wmask & {NP{up_awvalid}};
  assign dn_wvalid  = wmask & {NP{up_wvalid}};
  assign dn_bready  = wmask & {NP{up_bready}};
  assign dn_arvalid = rmask & {NP{up_arvalid}};
  assign dn_rready  = rmask & {NP{up_rready}};

  assign up_awready = whit ? dn_awready[wsel] : (up_wvalid & up_bready);
  assign up_wready  = whit ? dn_wready[wsel]  : (up_awvalid & up_bready);
  assign up_bvalid  = whit ? dn_bvalid[wsel]  : (up_awvalid & up_wvalid);
  assign up_bresp   = whit ? dn_bresp[2*int'(wsel) +: 2] : DECERR;

  assign up_arready = rhit ? dn_arready[rsel] : up_rready;
  assign up_rvalid  = rhit ? dn_rvalid[rsel]  : up_arvalid;
  assign up_rdata   = rhit ? dn_rdata[DW*int'(rsel) +: DW] : '0;
  assign up_rresp   = rhit ? dn_rresp[2*int'(rsel) +: 2] : DECERR;

  always_comb begin
    assert_wr_onehot_R1: assert ($onehot0(dn_awvalid) && $onehot0(dn_wvalid));
    assert_rd_onehot_R2: assert ($onehot0(dn_arvalid));
    assert_ready_onehot_R5: assert ($onehot0(dn_bready) && $onehot0(dn_rready));
    if (!up_awvalid)
      assert_aw_drop_R8: assert (dn_awvalid == '0);
    if (!up_arvalid)
      assert_ar_drop_R8: assert (dn_arvalid == '0);
    if (!whit && up_bvalid)
      assert_wr_decerr_R6: assert (up_bresp == DECERR && dn_awvalid == '0);
    if (!rhit && up_rvalid)
      assert_rd_decerr_R6: assert (up_rdata == '0 && up_rresp == DECERR && dn_arvalid == '0);
  end
endmodule

// File: tb/tb_axil_split3.sv
module tb_axil_split3;
  localparam int AW = 32, DW = 32, NP = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] up_awaddr, up_araddr, dn_awaddr, dn_araddr;
  logic [2:0] up_awprot, up_arprot, dn_awprot, dn_arprot;
  logic up_awvalid, up_awready, up_wvalid, up_wready, up_bvalid, up_bready;
  logic up_arvalid, up_arready, up_rvalid, up_rready;
  logic [DW-1:0] up_wdata, up_rdata, dn_wdata;
  logic [DW/8-1:0] up_wstrb, dn_wstrb;
  logic [1:0] up_bresp, up_rresp;
  logic [NP-1:0] dn_awvalid, dn_awready, dn_wvalid, dn_wready, dn_bvalid, dn_bready;
  logic [NP-1:0] dn_arvalid, dn_arready, dn_rvalid, dn_rready;
  logic [2*NP-1:0] dn_bresp, dn_rresp;
  logic [DW*NP-1:0] dn_rdata;

  int errors = 0, checks = 0;
  bit done = 0;

  axil_split3 #(.AW(AW), .DW(DW), .NP(NP)) dut (.*);

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    up_awaddr = '0; up_awprot = '0; up_awvalid = 0; up_wdata = '0; up_wstrb = '0;
    up_wvalid = 0; up_bready = 0; up_araddr = '0; up_arprot = '0; up_arvalid = 0;
    up_rready = 0;
    dn_awready = '0; dn_wready = '0; dn_bvalid = '0; dn_arready = '0; dn_rvalid = '0;
    dn_bresp = {2'd2, 2'd1, 2'd0};
    dn_rresp = {2'd2, 2'd1, 2'd0};
    dn_rdata = {32'hC0DE_0002, 32'hC0DE_0001, 32'hC0DE_0000};
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic t_idle();
    idle_inputs();
    settle();
    chk("R8", "idle awvalid", 64'(dn_awvalid), 0);
    chk("R8", "idle arvalid", 64'(dn_arvalid), 0);
    chk("R8", "idle wvalid", 64'(dn_wvalid), 0);
    chk("R4", "idle bvalid", 64'(up_bvalid), 0);
    chk("R4", "idle rvalid", 64'(up_rvalid), 0);
  endtask

  task automatic t_write(int p);
    logic [NP-1:0] m;
    m = NP'(1) << p;
    idle_inputs();
    up_awaddr = AW'(p * 4) | 32'h1;
    up_awprot = 3'(p + 1);
    up_wdata = 32'h1357_9BD0 + DW'(p);
    up_wstrb = 4'hF;
    up_awvalid = 1; up_wvalid = 1; up_bready = 1;
    dn_awready = m; dn_wready = m; dn_bvalid = ~m;
    settle();
    chk("R1", "awvalid", 64'(dn_awvalid), 64'(m));
    chk("R1", "wvalid", 64'(dn_wvalid), 64'(m));
    chk("R5", "bready", 64'(dn_bready), 64'(m));
    chk("R3", "awaddr", 64'(dn_awaddr), 64'(AW'(p * 4) | 32'h1));
    chk("R3", "awprot", 64'(dn_awprot), 64'(p + 1));
    chk("R3", "wdata", 64'(dn_wdata), 64'(32'h1357_9BD0 + DW'(p)));
    chk("R3", "wstrb", 64'(dn_wstrb), 64'hF);
    chk("R4", "awready", 64'(up_awready), 1);
    chk("R4", "wready", 64'(up_wready), 1);
    chk("R4", "bvalid from selected", 64'(up_bvalid), 0);
    chk("R4", "bresp", 64'(up_bresp), 64'(p));
    dn_bvalid = m;
    settle();
    chk("R4", "bvalid raised", 64'(up_bvalid), 1);
    up_awvalid = 0; up_wvalid = 0; up_bready = 0;
    #1;
    chk("R8", "awvalid drop", 64'(dn_awvalid), 0);
    chk("R8", "wvalid drop", 64'(dn_wvalid), 0);
    chk("R5", "bready drop", 64'(dn_bready), 0);
  endtask

  task automatic t_read(int p);
    logic [NP-1:0] m;
    m = NP'(1) << p;
    idle_inputs();
    up_araddr = AW'(p * 4) | 32'h2;
    up_arprot = 3'(5 - p);
    up_arvalid = 1; up_rready = 1;
    dn_rvalid = m; dn_arready = ~m;
    settle();
    chk("R2", "arvalid", 64'(dn_arvalid), 64'(m));
    chk("R5", "rready", 64'(dn_rready), 64'(m));
    chk("R3", "araddr", 64'(dn_araddr), 64'(AW'(p * 4) | 32'h2));
    chk("R3", "arprot", 64'(dn_arprot), 64'(5 - p));
    chk("R4", "rvalid", 64'(up_rvalid), 1);
    chk("R4", "arready from selected", 64'(up_arready), 0);
    chk("R4", "rdata", 64'(up_rdata), 64'(32'hC0DE_0000 + p));
    chk("R4", "rresp", 64'(up_rresp), 64'(p));
    up_arvalid = 0;
    #1;
    chk("R8", "arvalid drop", 64'(dn_arvalid), 0);
  endtask

  task automatic t_unmapped_write(logic [AW-1:0] a);
    idle_inputs();
    up_awaddr = a; up_wdata = 32'hDEAD_0000; up_wstrb = 4'h3;
    up_awvalid = 1; up_wvalid = 1; up_bready = 1;
    dn_awready = '1; dn_wready = '1; dn_bvalid = '1;
    settle();
    chk("R6", "unmapped awvalid", 64'(dn_awvalid), 0);
    chk("R6", "unmapped wvalid", 64'(dn_wvalid), 0);
    chk("R6", "unmapped bready", 64'(dn_bready), 0);
    chk("R6", "unmapped bvalid", 64'(up_bvalid), 1);
    chk("R6", "unmapped bresp", 64'(up_bresp), 3);
    chk("R6", "unmapped awready", 64'(up_awready), 1);
    chk("R6", "unmapped wready", 64'(up_wready), 1);
    chk("R3", "unmapped wstrb", 64'(dn_wstrb), 3);
    up_bready = 0;
    #1;
    chk("R6", "awready waits bready", 64'(up_awready), 0);
    chk("R6", "bvalid held", 64'(up_bvalid), 1);
    up_wvalid = 0;
    #1;
    chk("R6", "bvalid needs wvalid", 64'(up_bvalid), 0);
  endtask

  task automatic t_unmapped_read(logic [AW-1:0] a);
    idle_inputs();
    up_araddr = a; up_arvalid = 1; up_rready = 0;
    dn_rvalid = '1; dn_arready = '1;
    settle();
    chk("R6", "unmapped arvalid", 64'(dn_arvalid), 0);
    chk("R6", "unmapped rvalid", 64'(up_rvalid), 1);
    chk("R6", "unmapped rdata", 64'(up_rdata), 0);
    chk("R6", "unmapped rresp", 64'(up_rresp), 3);
    chk("R6", "arready follows rready low", 64'(up_arready), 0);
    up_rready = 1;
    #1;
    chk("R6", "arready follows rready", 64'(up_arready), 1);
    chk("R6", "unmapped rready", 64'(dn_rready), 0);
  endtask

  task automatic t_concurrent();
    idle_inputs();
    up_awaddr = 32'h0; up_awvalid = 1; up_wvalid = 1; up_bready = 1;
    up_araddr = 32'h8; up_arvalid = 1; up_rready = 1;
    dn_bvalid = 3'b001; dn_rvalid = 3'b100; dn_awready = 3'b001; dn_arready = 3'b100;
    settle();
    chk("R7", "wr port0 awvalid", 64'(dn_awvalid), 64'b001);
    chk("R7", "rd port2 arvalid", 64'(dn_arvalid), 64'b100);
    chk("R7", "bresp port0", 64'(up_bresp), 0);
    chk("R7", "rresp port2", 64'(up_rresp), 2);
    chk("R7", "rdata port2", 64'(up_rdata), 64'h C0DE_0002);
    chk("R7", "both ready", 64'({up_awready, up_arready}), 64'b11);
    up_araddr = 32'hC;
    #1;
    chk("R7", "write kept during unmapped read", 64'(dn_awvalid), 64'b001);
    chk("R7", "unmapped read beside write", 64'(up_rresp), 3);
    chk("R7", "write bvalid unaffected", 64'(up_bvalid), 1);
  endtask

  initial begin
    idle_inputs();
    t_idle();
    for (int p = 0; p < NP; p++) t_write(p);
    for (int p = 0; p < NP; p++) t_read(p);
    t_unmapped_write(32'h0000_000C);
    t_unmapped_write(32'h0000_0104);
    t_unmapped_read(32'h0000_000C);
    t_unmapped_read(32'h1000_0008);
    t_concurrent();
    t_idle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule